// File: doc/BRIEF.md
# Keyed Runaway-Detection Watchdog

This block watches for a processor that has stopped servicing its software loop. A prescaler divides the system clock into count ticks. A binary counter advances on each tick. One of four counter taps, picked by a two-bit period field, sets the overflow interval. Each time the selected tap overflows, the block raises a one-cycle non-maskable interrupt request. If the routing bit is set, the overflow also sets a sticky internal reset request, which only the system reset clears.

Software reaches the block through a byte-wide write-only register port with two addresses. Address 0 is the mode register. Address 1 is the key register. Only two byte values written to the key register have any effect. 0x4E restarts the period. 0xB1 stops the watchdog, but only after the enable bit in the mode register has already been cleared. The port has no back-pressure: a write is taken in the cycle where `reg_we` is high. The outputs are plain level signals.

Top module: `runaway_wdog`

## Requirements
- R1: After reset, `nmi_req` and `int_rst_req` are 0. The mode register holds enable=1, period=0 and routing=0, so the first request comes exactly 2^(TAP_BASE+PRE_LOG2) cycles after reset is released.
- R2: The mode register takes the enable bit at bit 7, the period field at bits 5:4 and the routing bit at bit 2. For period value p, requests repeat every 2^(TAP_BASE+TAP_STEP*p+PRE_LOG2) clock cycles.
- R3: `nmi_req` is high for exactly one cycle per overflow. The counter keeps running, so the request comes back every period.
- R4: Writing 0x4E to the key register (address 1) clears the prescaler and the counter. The next request comes exactly one full period after the write edge.
- R5: A key register byte other than 0x4E or 0xB1 has no effect on the counting.
- R6: Writing 0xB1 to the key register while the enable bit is 0 stops the watchdog. No request is raised while it is stopped.
- R7: Writing 0xB1 while the enable bit is 1 is ignored, and counting continues undisturbed.
- R8: Writing enable=0 to the mode register does not stop counting on its own. Writing enable=1 to a stopped watchdog restarts it from zero, and the first request comes one full period after that write.
- R9: With the routing bit at 1, an overflow raises `int_rst_req` in the same cycle as `nmi_req`. It stays high, even across key writes, until `rst_n` is asserted.
- R10: With the routing bit at 0, overflows never raise `int_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode register, 1 = key register |
| reg_wdata | input | 8 | Write data byte |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on overflow |
| int_rst_req | output | 1 | Sticky internal reset request |

## Verification
A counter or prescaler that drifts, or a wrong tap decode, shows up as a request arriving at the wrong cycle. The bench measures every interval exactly, so such a fault is seen within one period, at most 256 cycles in the small bench configuration. A bad key or enable state shows up as one of two things. Either a request arrives while the block should be stopped, or the phase fails to restart after a clear, and the next request is late or early. A wrong latch state shows up as `int_rst_req` appearing without routing, or dropping before reset.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  localparam logic [7:0] KEY_RESTART = 8'h4E;
  localparam logic [7:0] KEY_STOP    = 8'hB1;
  localparam int MODE_ON_BIT   = 7;
  localparam int MODE_SPAN_LSB = 4;
  localparam int MODE_RST_BIT  = 2;

  typedef struct packed {
    logic       on;
    logic [1:0] span;
    logic       to_rst;
  } mode_t;
endpackage

// File: rtl/rwd_prescale.sv
module rwd_prescale #(
  parameter int PRE_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (PRE_LOG2 == 0) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PRE_LOG2-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               div_q <= '0;
        else if (!run || restart) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
      end
      assign tick = run && (&div_q);
    end
  endgenerate
endmodule

// File: rtl/rwd_chain.sv
module rwd_chain #(
  parameter int STAGES   = 22,
  parameter int TAP_BASE = 15,
  parameter int TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] span,
  output logic       ovf
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] low_mask;
  int                tap_idx;

  always_comb begin
    tap_idx = TAP_BASE + TAP_STEP * int'(span);
    for (int i = 0; i < STAGES; i++) low_mask[i] = (i < tap_idx);
  end

  assign ovf = run && tick && ((cnt_q & low_mask) == low_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/rwd_regs.sv
module rwd_regs
  import rwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output mode_t      mode,
  output logic       run,
  output logic       restart
);
  logic mode_wr, key_wr, stop_cmd;

  assign mode_wr  = reg_we && !reg_addr;
  assign key_wr   = reg_we && reg_addr;
  assign restart  = key_wr && (reg_wdata == KEY_RESTART);
  assign stop_cmd = key_wr && (reg_wdata == KEY_STOP) && !mode.on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '{on: 1'b1, span: 2'b00, to_rst: 1'b0};
      run  <= 1'b1;
    end else begin
      if (mode_wr) begin
        mode.on     <= reg_wdata[MODE_ON_BIT];
        mode.span   <= reg_wdata[MODE_SPAN_LSB +: 2];
        mode.to_rst <= reg_wdata[MODE_RST_BIT];
      end
      if (mode_wr && reg_wdata[MODE_ON_BIT]) run <= 1'b1;
      else if (stop_cmd)                     run <= 1'b0;
    end
  end

  // R6
  stop_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(key_wr && reg_wdata == KEY_STOP && !mode.on));
  // R7
  enabled_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode.on && !mode_wr) |=> run);
endmodule

// File: rtl/runaway_wdog.sv
module runaway_wdog
  import rwd_pkg::*;
#(
  parameter int STAGES   = 22,
  parameter int TAP_BASE = 15,
  parameter int TAP_STEP = 2,
  parameter int PRE_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       nmi_req,
  output logic       int_rst_req
);
  mode_t mode;
  logic  run, restart, tick, ovf;

  rwd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode(mode), .run(run), .restart(restart)
  );

  rwd_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick)
  );

  rwd_chain #(.STAGES(STAGES), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_chain (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick),
    .span(mode.span), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_req     <= 1'b0;
      int_rst_req <= 1'b0;
    end else begin
      nmi_req <= ovf;
      if (ovf && mode.to_rst) int_rst_req <= 1'b1;
    end
  end

  // R3
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);
  // R9
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_req |=> int_rst_req);
  // R9
  rst_with_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst_req) |-> nmi_req);
  // R10
  rst_needs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst_req) |-> $past(mode.to_rst));
endmodule

// File: tb/runaway_wdog_tb_top.sv
module runaway_wdog_tb_top;
  localparam int ST = 8, TB = 1, TS = 2, PL = 1;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic nmi_req, int_rst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  runaway_wdog #(.STAGES(ST), .TAP_BASE(TB), .TAP_STEP(TS), .PRE_LOG2(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .nmi_req(nmi_req), .int_rst_req(int_rst_req)
  );

  function automatic int period(int p);
    return 1 << (TB + TS * p + PL);
  endfunction

  function automatic logic [7:0] mode_byte(bit on, int p, bit rt);
    logic [7:0] b = '0;
    b[7] = on; b[5:4] = p[1:0]; b[2] = rt;
    return b;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  // edges counted until nmi_req seen; returns limit+1 if none
  task automatic wait_nmi(int limit, output int n);
    n = 0;
    while (n <= limit) begin
      @(posedge clk); #1; n++;
      if (nmi_req) return;
    end
  endtask

  initial begin
    int n;
    #3;
    check("R1 nmi reset", int'(nmi_req), 0);
    check("R1 rst reset", int'(int_rst_req), 0);
    @(negedge clk); rst_n = 1'b1;
    wait_nmi(2000, n);
    check("R1 first period", n, period(0));
    @(posedge clk); #1;
    check("R3 single cycle", int'(nmi_req), 0);

    for (int p = 0; p < 4; p++) begin
      wr(1'b0, mode_byte(1, p, 0));
      wr(1'b1, 8'h4E);
      wait_nmi(2000, n);
      check("R4 restart period", n, period(p));
      wait_nmi(2000, n);
      check("R2 repeat period", n, period(p));
      @(posedge clk); #1;
      check("R3 pulse width", int'(nmi_req), 0);
      check("R10 no route", int'(int_rst_req), 0);
    end

    for (int p = 0; p < 2; p++) begin
      wr(1'b0, mode_byte(1, p, 0));
      wr(1'b1, 8'h4E);
      wr(1'b1, 8'h55);
      wait_nmi(2000, n);
      check("R5 other byte ignored", n, period(p) - 1);
      wr(1'b1, 8'h4E);
      wr(1'b1, 8'hB1);
      wait_nmi(2000, n);
      check("R7 stop while enabled ignored", n, period(p) - 1);
    end

    wr(1'b0, mode_byte(0, 0, 0));
    wr(1'b1, 8'h4E);
    wait_nmi(2000, n);
    check("R8 enable=0 keeps counting", n, period(0));
    wr(1'b1, 8'hB1);
    wait_nmi(16 * period(0), n);
    check("R6 stopped no request", n, 16 * period(0) + 1);
    wr(1'b1, 8'h4E);
    wait_nmi(8 * period(0), n);
    check("R6 restart key while stopped", n, 8 * period(0) + 1);
    wr(1'b0, mode_byte(1, 1, 0));
    wait_nmi(2000, n);
    check("R8 re-enable from zero", n, period(1));

    wr(1'b0, mode_byte(1, 0, 1));
    wr(1'b1, 8'h4E);
    check("R10 before overflow", int'(int_rst_req), 0);
    wait_nmi(2000, n);
    check("R9 overflow period", n, period(0));
    check("R9 rst with nmi", int'(int_rst_req), 1);
    wr(1'b1, 8'h4E);
    repeat (10) @(posedge clk);
    #1;
    check("R9 rst sticky", int'(int_rst_req), 1);
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R9 rst cleared by reset", int'(int_rst_req), 0);
    check("R1 nmi cleared by reset", int'(nmi_req), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule